// File: doc/BRIEF.md
# DMA Channel Error Status Tracker

This block records fault conditions for the channels of a multi-channel DMA controller and lets software inspect and acknowledge them. Two kinds of fault are captured. The transfer engine can report a bus error against a channel. The descriptor fetch path can present the cycle-control field of a descriptor it has just read, and a field of all zeros marks that descriptor as invalid. Each event arrives as its own strobe tagged with a channel index, so one bus error and one descriptor check for different channels can land in the same clock cycle.

Software sees three 32-bit views over a small register port: a bus-error view, an invalid-descriptor view, and a combined view that shows the OR of the two. Every view is write-one-to-clear. Writing the combined view clears both underlying flags of a channel. Reads are combinational on the current address.

Each captured fault also produces a one-cycle pulse on a per-channel disable vector toward the channel enable logic. Only the faulting channel is stopped, and the pulse repeats on every new fault, even when that channel is already flagged.

Top module: `dma_err_tracker`

## Requirements
- R1: After a synchronous active-low reset, all three views read zero and the disable vector is all zero.
- R2: Bits [31:24] of every view read zero. A read at any address other than 0x48, 0x4C and 0x50 returns zero. Writes to reserved bits or to unmapped addresses change no flag.
- R3: A bus-error strobe for channel n (n < 24) sets bit n of the bus-error view (0x4C) and of the combined view (0x48). The flag is readable in the cycle after the strobe.
- R4: A descriptor strobe for channel n whose 3-bit cycle-control value is 3'b000 sets bit n of the invalid-descriptor view (0x50) and of the combined view. Any non-zero value has no effect.
- R5: Writing 1 to bit n of 0x4C or 0x50 clears that flag. A 0 bit in the write data leaves the flag unchanged.
- R6: Bit n of the combined view reads as the OR of the bus-error and invalid-descriptor flags of channel n. Writing 1 to bit n at 0x48 clears both flags.
- R7: Each captured fault on channel n raises bit n, and only bit n, of `chan_disable` for exactly the one cycle after the strobe. The pulse is issued again when the flag is already set.
- R8: When a fault strobe and a clearing write hit the same channel flag in one cycle, the flag stays set.
- R9: A bus-error strobe and an invalid-descriptor strobe for different channels in the same cycle are both captured, and both disable bits pulse together.
- R10: A strobe whose channel index is 24 or above changes no flag and raises no disable bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| berr_valid | input | 1 | Bus-error strobe from the transfer engine |
| berr_chan | input | 5 | Channel index of the bus error |
| desc_valid | input | 1 | Descriptor-check strobe from the fetch path |
| desc_chan | input | 5 | Channel index of the fetched descriptor |
| desc_cc | input | 3 | Cycle-control field of the fetched descriptor |
| reg_wr | input | 1 | Register write enable |
| reg_addr | input | 8 | Register byte offset, used for reads and writes |
| reg_wdata | input | 32 | Write data; ones clear flags |
| reg_rdata | output | 32 | Combinational read data |
| chan_disable | output | 24 | One-cycle per-channel disable pulses |

## Verification
The bench uses bus-error strobes alone, descriptor strobes with both zero and non-zero cycle-control values, and both strobe kinds together on different channels. These patterns show whether the two fault sources land in their own views and whether the combined view merges them correctly. It repeats a fault on a flagged channel and collides a fault with a clearing write on the same channel. These cases separate a disable pulse tied to the event from one tied to the flag edge, and show whether a set beats a clear. It also sends out-of-range channel indices, zero-bit and reserved-bit writes, and unmapped addresses, to show that these leave all state untouched.

// File: rtl/dma_err_pkg.sv
// Package: shared constants for the DMA error status tracker.
// Assumes byte offsets inside an 8-bit register window.
package dma_err_pkg;
    localparam int unsigned REG_ADDR_W = 8;
    localparam int unsigned REG_DATA_W = 32;
    localparam int unsigned CC_W       = 3;

    localparam logic [REG_ADDR_W-1:0] OFF_ALL_ERR  = 8'h48;
    localparam logic [REG_ADDR_W-1:0] OFF_BUS_ERR  = 8'h4C;
    localparam logic [REG_ADDR_W-1:0] OFF_BAD_DESC = 8'h50;

    localparam logic [CC_W-1:0] CC_INVALID = 3'b000;
endpackage

// File: rtl/dma_evt_decode.sv
// Module: turns a tagged event strobe into a one-hot channel vector.
// Assumes indices at or above NUM_CH are dropped (no bit is raised).
module dma_evt_decode #(
    parameter int unsigned NUM_CH = 24,
    parameter int unsigned IDX_W  = 5
) (
    input  logic              valid,
    input  logic [IDX_W-1:0]  chan,
    output logic [NUM_CH-1:0] hot
);
    // One comparator per channel; out-of-range indices match none.
    for (genvar i = 0; i < NUM_CH; i++) begin : g_dec
        assign hot[i] = valid && (chan == IDX_W'(i));
    end
endmodule

// File: rtl/dma_w1c_bank.sv
// Module: bank of sticky flags with per-bit set and clear.
// Assumes set has priority over clear in the same cycle.
module dma_w1c_bank #(
    parameter int unsigned NUM_CH = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] set,
    input  logic [NUM_CH-1:0] clr,
    output logic [NUM_CH-1:0] flags
);
    // Sticky update: clear first, then OR in new sets so a set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) flags <= '0;
        else        flags <= (flags & ~clr) | set;
    end
endmodule

// File: rtl/dma_err_regs.sv
// Module: register port for the three status views.
// Assumes a combinational read on reg_addr and a single-cycle write strobe.
module dma_err_regs
    import dma_err_pkg::*;
#(
    parameter int unsigned NUM_CH = 24
) (
    input  logic                  reg_wr,
    input  logic [REG_ADDR_W-1:0] reg_addr,
    input  logic [REG_DATA_W-1:0] reg_wdata,
    input  logic [NUM_CH-1:0]     bus_flags,
    input  logic [NUM_CH-1:0]     desc_flags,
    output logic [NUM_CH-1:0]     bus_clr,
    output logic [NUM_CH-1:0]     desc_clr,
    output logic [REG_DATA_W-1:0] reg_rdata
);
    logic [NUM_CH-1:0] wr_ones;
    assign wr_ones = reg_wdata[NUM_CH-1:0];

    // Reserved write bits are dropped on purpose.
    if (NUM_CH < REG_DATA_W) begin : g_rsvd
        logic unused_rsvd;
        assign unused_rsvd = ^reg_wdata[REG_DATA_W-1:NUM_CH];
    end

    // Clear decode: the combined view clears both banks.
    always_comb begin
        bus_clr  = '0;
        desc_clr = '0;
        if (reg_wr) begin
            unique case (reg_addr)
                OFF_ALL_ERR: begin
                    bus_clr  = wr_ones;
                    desc_clr = wr_ones;
                end
                OFF_BUS_ERR:  bus_clr  = wr_ones;
                OFF_BAD_DESC: desc_clr = wr_ones;
                default: ;
            endcase
        end
    end

    // Read mux: zero-extended flags, zero for unmapped offsets.
    always_comb begin
        unique case (reg_addr)
            OFF_ALL_ERR:  reg_rdata = REG_DATA_W'(bus_flags | desc_flags);
            OFF_BUS_ERR:  reg_rdata = REG_DATA_W'(bus_flags);
            OFF_BAD_DESC: reg_rdata = REG_DATA_W'(desc_flags);
            default:      reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/dma_err_tracker.sv
// Module: top of the DMA channel error status tracker.
// Captures bus errors and invalid descriptors per channel, serves three
// write-one-to-clear views and pulses a per-channel disable.
// Assumes event strobes are single-cycle and already synchronous to clk.
module dma_err_tracker
    import dma_err_pkg::*;
#(
    parameter int unsigned NUM_CH   = 24,
    parameter int unsigned CH_IDX_W = $clog2(NUM_CH)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  berr_valid,
    input  logic [CH_IDX_W-1:0]   berr_chan,
    input  logic                  desc_valid,
    input  logic [CH_IDX_W-1:0]   desc_chan,
    input  logic [CC_W-1:0]       desc_cc,
    input  logic                  reg_wr,
    input  logic [REG_ADDR_W-1:0] reg_addr,
    input  logic [REG_DATA_W-1:0] reg_wdata,
    output logic [REG_DATA_W-1:0] reg_rdata,
    output logic [NUM_CH-1:0]     chan_disable
);
    logic              desc_bad;
    logic [NUM_CH-1:0] bus_hit, desc_hit;
    logic [NUM_CH-1:0] bus_clr, desc_clr;
    logic [NUM_CH-1:0] bus_flags, desc_flags;
    logic [NUM_CH-1:0] dis_q;

    // A descriptor is faulty only when its cycle-control field is zero.
    assign desc_bad = desc_valid && (desc_cc == CC_INVALID);

    dma_evt_decode #(.NUM_CH(NUM_CH), .IDX_W(CH_IDX_W)) u_bus_dec (
        .valid(berr_valid), .chan(berr_chan), .hot(bus_hit)
    );

    dma_evt_decode #(.NUM_CH(NUM_CH), .IDX_W(CH_IDX_W)) u_desc_dec (
        .valid(desc_bad), .chan(desc_chan), .hot(desc_hit)
    );

    dma_w1c_bank #(.NUM_CH(NUM_CH)) u_bus_bank (
        .clk(clk), .rst_n(rst_n), .set(bus_hit), .clr(bus_clr), .flags(bus_flags)
    );

    dma_w1c_bank #(.NUM_CH(NUM_CH)) u_desc_bank (
        .clk(clk), .rst_n(rst_n), .set(desc_hit), .clr(desc_clr), .flags(desc_flags)
    );

    dma_err_regs #(.NUM_CH(NUM_CH)) u_regs (
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .bus_flags(bus_flags), .desc_flags(desc_flags),
        .bus_clr(bus_clr), .desc_clr(desc_clr), .reg_rdata(reg_rdata)
    );

    // Disable pulse: one cycle per captured event, independent of flag state.
    always_ff @(posedge clk) begin
        if (!rst_n) dis_q <= '0;
        else        dis_q <= bus_hit | desc_hit;
    end

    assign chan_disable = dis_q;
endmodule

// File: rtl/dma_err_tracker_chk.sv
// Module: assertion checker for dma_err_tracker, attached by bind.
// Assumes it observes the top's ports plus the two internal flag banks.
module dma_err_tracker_chk
    import dma_err_pkg::*;
#(
    parameter int unsigned NUM_CH   = 24,
    parameter int unsigned CH_IDX_W = 5
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  berr_valid,
    input logic [CH_IDX_W-1:0]   berr_chan,
    input logic                  desc_valid,
    input logic [CH_IDX_W-1:0]   desc_chan,
    input logic [CC_W-1:0]       desc_cc,
    input logic                  reg_wr,
    input logic [REG_ADDR_W-1:0] reg_addr,
    input logic [REG_DATA_W-1:0] reg_wdata,
    input logic [REG_DATA_W-1:0] reg_rdata,
    input logic [NUM_CH-1:0]     chan_disable,
    input logic [NUM_CH-1:0]     bus_flags,
    input logic [NUM_CH-1:0]     desc_flags
);
    logic [NUM_CH-1:0] exp_bus, exp_desc;

    // Independent one-hot of expected events, computed from the ports.
    always_comb begin
        exp_bus  = '0;
        exp_desc = '0;
        if (berr_valid && (int'(berr_chan) < int'(NUM_CH)))
            exp_bus[berr_chan] = 1'b1;
        if (desc_valid && (desc_cc == 3'b000) && (int'(desc_chan) < int'(NUM_CH)))
            exp_desc[desc_chan] = 1'b1;
    end

    p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[REG_DATA_W-1:NUM_CH] == '0);

    p_unmapped_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr != 8'h48 && reg_addr != 8'h4C && reg_addr != 8'h50) |-> reg_rdata == '0);

    // Also covers R8 and R9: a set survives any same-cycle clear.
    p_bus_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (|exp_bus) |=> ((bus_flags & $past(exp_bus)) == $past(exp_bus)));

    p_desc_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (|exp_desc) |=> ((desc_flags & $past(exp_desc)) == $past(exp_desc)));

    p_bus_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 8'h4C && exp_bus == '0)
        |=> ((bus_flags & $past(reg_wdata[NUM_CH-1:0])) == '0));

    p_comb_or_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == 8'h48) |-> (reg_rdata[NUM_CH-1:0] == (bus_flags | desc_flags)));

    p_dis_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (|(exp_bus | exp_desc)) |=> (chan_disable == $past(exp_bus | exp_desc)));

    p_dis_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (exp_bus == '0 && exp_desc == '0) |=> (chan_disable == '0));

    p_dis_count_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(chan_disable) <= 2);
endmodule

bind dma_err_tracker dma_err_tracker_chk #(
    .NUM_CH(NUM_CH), .CH_IDX_W(CH_IDX_W)
) u_chk (
    .clk(clk), .rst_n(rst_n),
    .berr_valid(berr_valid), .berr_chan(berr_chan),
    .desc_valid(desc_valid), .desc_chan(desc_chan), .desc_cc(desc_cc),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .chan_disable(chan_disable),
    .bus_flags(bus_flags), .desc_flags(desc_flags)
);

// File: tb/dma_err_tracker_test.sv
// Bench: directed scenarios for dma_err_tracker, one task each.
module dma_err_tracker_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        berr_valid, desc_valid, reg_wr;
    logic [4:0]  berr_chan, desc_chan;
    logic [2:0]  desc_cc;
    logic [7:0]  reg_addr;
    logic [31:0] reg_wdata, reg_rdata;
    logic [23:0] chan_disable;

    int checks = 0;
    int fails  = 0;
    logic [23:0] m_bus = '0, m_desc = '0;

    always #10 clk = ~clk;

    dma_err_tracker uut (
        .clk(clk), .rst_n(rst_n),
        .berr_valid(berr_valid), .berr_chan(berr_chan),
        .desc_valid(desc_valid), .desc_chan(desc_chan), .desc_cc(desc_cc),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .chan_disable(chan_disable)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Apply one cycle of stimulus from a falling edge to the next one.
    task automatic step(input logic bv, input logic [4:0] bc,
                        input logic dv, input logic [4:0] dc, input logic [2:0] cc,
                        input logic wr, input logic [7:0] a, input logic [31:0] wd);
        berr_valid = bv; berr_chan = bc;
        desc_valid = dv; desc_chan = dc; desc_cc = cc;
        reg_wr = wr; reg_addr = a; reg_wdata = wd;
        @(negedge clk);
        berr_valid = 1'b0; desc_valid = 1'b0; reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    // Compare all three views against the bench model.
    task automatic check_views(input string tag);
        logic [31:0] d;
        rd(8'h4C, d); check({tag, " bus view"}, d, {8'h00, m_bus});
        rd(8'h50, d); check({tag, " desc view"}, d, {8'h00, m_desc});
        rd(8'h48, d); check({tag, " all view"}, d, {8'h00, m_bus | m_desc});
    endtask

    task automatic t_reset;
        check("R1 disable after reset", {8'h0, chan_disable}, 32'h0);
        check_views("R1 reset");
    endtask

    task automatic t_bus_error;
        step(1'b1, 5'd5, 1'b0, 5'd0, 3'd1, 1'b0, 8'h4C, 32'h0);
        m_bus[5] = 1'b1;
        check("R7 disable pulse ch5", {8'h0, chan_disable}, 32'h0000_0020);
        check_views("R3 bus ch5");
        step(1'b0, 5'd0, 1'b0, 5'd0, 3'd1, 1'b0, 8'h4C, 32'h0);
        check("R7 pulse lasts one cycle", {8'h0, chan_disable}, 32'h0);
    endtask

    task automatic t_descriptor;
        step(1'b0, 5'd0, 1'b1, 5'd23, 3'b010, 1'b0, 8'h50, 32'h0);
        check("R4 nonzero cc no disable", {8'h0, chan_disable}, 32'h0);
        check_views("R4 nonzero cc");
        step(1'b0, 5'd0, 1'b1, 5'd23, 3'b000, 1'b0, 8'h50, 32'h0);
        m_desc[23] = 1'b1;
        check("R4 invalid desc disable ch23", {8'h0, chan_disable}, 32'h0080_0000);
        check_views("R4 invalid ch23");
    endtask

    task automatic t_w1c;
        step(1'b0, 5'd0, 1'b0, 5'd0, 3'd1, 1'b1, 8'h4C, 32'h0000_0000);
        check_views("R5 zero write");
        step(1'b0, 5'd0, 1'b0, 5'd0, 3'd1, 1'b1, 8'h4C, 32'hFF00_0020);
        m_bus[5] = 1'b0;
        check_views("R5 clear bus ch5");
        step(1'b0, 5'd0, 1'b0, 5'd0, 3'd1, 1'b1, 8'h50, 32'h0080_0000);
        m_desc[23] = 1'b0;
        check_views("R5 clear desc ch23");
    endtask

    task automatic t_combined;
        step(1'b1, 5'd7, 1'b0, 5'd0, 3'd1, 1'b0, 8'h48, 32'h0);
        step(1'b0, 5'd0, 1'b1, 5'd7, 3'b000, 1'b0, 8'h48, 32'h0);
        step(1'b0, 5'd0, 1'b1, 5'd9, 3'b000, 1'b0, 8'h48, 32'h0);
        m_bus[7] = 1'b1; m_desc[7] = 1'b1; m_desc[9] = 1'b1;
        check_views("R6 merged view");
        step(1'b0, 5'd0, 1'b0, 5'd0, 3'd1, 1'b1, 8'h48, 32'h0000_0080);
        m_bus[7] = 1'b0; m_desc[7] = 1'b0;
        check_views("R6 combined clear ch7");
        step(1'b0, 5'd0, 1'b0, 5'd0, 3'd1, 1'b1, 8'h48, 32'h0000_0200);
        m_desc[9] = 1'b0;
        check_views("R6 combined clear ch9");
    endtask

    task automatic t_dual;
        step(1'b1, 5'd0, 1'b1, 5'd12, 3'b000, 1'b0, 8'h48, 32'h0);
        m_bus[0] = 1'b1; m_desc[12] = 1'b1;
        check("R9 both disables", {8'h0, chan_disable}, 32'h0000_1001);
        check_views("R9 both captured");
    endtask

    task automatic t_set_wins;
        step(1'b1, 5'd0, 1'b0, 5'd0, 3'd1, 1'b1, 8'h4C, 32'h0000_0001);
        check("R7 repeat pulse on set flag", {8'h0, chan_disable}, 32'h0000_0001);
        check_views("R8 set beats clear");
        step(1'b0, 5'd0, 1'b1, 5'd12, 3'b000, 1'b1, 8'h48, 32'h0000_1000);
        check_views("R8 set beats combined clear");
        step(1'b0, 5'd0, 1'b0, 5'd0, 3'd1, 1'b1, 8'h48, 32'h00FF_FFFF);
        m_bus = '0; m_desc = '0;
        check_views("R6 clear all");
    endtask

    task automatic t_range;
        step(1'b1, 5'd30, 1'b1, 5'd24, 3'b000, 1'b0, 8'h48, 32'h0);
        check("R10 no disable out of range", {8'h0, chan_disable}, 32'h0);
        check_views("R10 out of range");
    endtask

    task automatic t_unmapped;
        logic [31:0] d;
        step(1'b1, 5'd3, 1'b0, 5'd0, 3'd1, 1'b0, 8'h48, 32'h0);
        m_bus[3] = 1'b1;
        rd(8'h44, d); check("R2 unmapped read 0x44", d, 32'h0);
        rd(8'h54, d); check("R2 unmapped read 0x54", d, 32'h0);
        step(1'b0, 5'd0, 1'b0, 5'd0, 3'd1, 1'b1, 8'h44, 32'hFFFF_FFFF);
        check_views("R2 unmapped write");
        step(1'b0, 5'd0, 1'b0, 5'd0, 3'd1, 1'b1, 8'h4C, 32'hFF00_0000);
        check_views("R2 reserved write");
    endtask

    task automatic report;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        #(20 * 100000);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        rst_n = 1'b0;
        berr_valid = 1'b0; berr_chan = '0;
        desc_valid = 1'b0; desc_chan = '0; desc_cc = 3'd1;
        reg_wr = 1'b0; reg_addr = 8'h48; reg_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_bus_error();
        t_descriptor();
        t_w1c();
        t_combined();
        t_dual();
        t_set_wins();
        t_range();
        t_unmapped();
        report();
    end
endmodule